// File: doc/BRIEF.md
# Windowed Watchdog with Fault-Recovery Window

This block supervises a microcontroller through a periodic refresh strobe. After leaving its init phase it runs a normal window of fixed length. The window has a closed part at the start and an open part after it. A good refresh in the open part restarts the window. A refresh in the closed part, a refresh marked bad, or no refresh before the window ends raises a one-cycle error flag, and the window then starts again.

An external fault line, active high, latches a safe-state output. If fault recovery is enabled, a fault that is still present while the safe-state output is high moves the watchdog into a recovery window. The recovery window has no closed part, and its length comes from a 4-bit code that can only be written during init. A good refresh inside the recovery window does one of two things:
- If the fault has cleared, the watchdog returns to normal operation.
- If the fault is still present, a new recovery window starts.

If the recovery window runs out, the block emits a reset pulse of fixed width and then goes back to init.

Top module: `wdog_recov`

## Requirements
- R1: After reset, `in_init_o` is 1 and all other outputs are 0. The recovery code starts at `REC_CODE_RST`, so with the default of 2 the recovery window is 3·`REC_STEP_CYC` cycles.
- R2: During init, a one-cycle `init_done_i` moves the block to normal operation and window position 0. During init, `cfg_wr_i` loads `cfg_rec_code_i`.
- R3: `cfg_wr_i` outside init has no effect on the recovery window length.
- R4: In normal operation, a refresh at window position p < `CLOSED_CYC` raises `wd_err_o` for one cycle, one cycle later. A good refresh at p ≥ `CLOSED_CYC` raises no error. Any refresh restarts the window at position 0.
- R5: If no refresh arrives in normal operation, `wd_err_o` pulses in the cycle after position `PERIOD_CYC`-1, and the window restarts.
- R6: A refresh with `refresh_good_i`=0 in normal operation raises `wd_err_o`, even in the open part.
- R7: `safe_state_o` goes to 1 one cycle after `fault_i` is high while the block is in normal or recovery operation. It stays latched until a recovery exit or a reset pulse.
- R8: When `recov_en_i`, `fault_i` and `safe_state_o` are all 1 in normal operation, `in_recov_o` goes to 1 at the next edge, at recovery position 0.
- R9: The recovery window lasts (code+1)·`REC_STEP_CYC` cycles, so code 7 gives 8 steps. A good refresh at any position, including position 0, is accepted. A refresh marked bad has no effect.
- R10: A good refresh in recovery while `fault_i`=0 clears `in_recov_o` and `safe_state_o` at the next edge, and starts a fresh normal window.
- R11: A good refresh in recovery while `fault_i`=1 keeps the block in recovery and starts a full new recovery window.
- R12: If the recovery window expires, `rst_pulse_o` is high for exactly `RST_PULSE_CYC` cycles, `safe_state_o` clears, and `in_init_o` is 1 afterwards.
- R13: With `recov_en_i`=0, a fault never leads to recovery, and the normal-window errors continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done_i | input | 1 | Leave init and start normal operation |
| cfg_wr_i | input | 1 | Write strobe for the recovery code (honoured only in init) |
| cfg_rec_code_i | input | 4 | Recovery length code |
| recov_en_i | input | 1 | Fault-recovery enable |
| fault_i | input | 1 | External fault indication, active high |
| refresh_i | input | 1 | Refresh strobe |
| refresh_good_i | input | 1 | Qualifies a refresh as good (1) or bad (0) |
| safe_state_o | output | 1 | Latched safe-state output |
| wd_err_o | output | 1 | One-cycle watchdog error flag |
| rst_pulse_o | output | 1 | Reset pulse |
| in_init_o | output | 1 | Block is in its init phase |
| in_recov_o | output | 1 | Recovery window active |

## Verification
The hardest state to reach is a recovery window that is restarted by a refresh while the fault is still present, and then left to time out. Reaching it takes a latched safe state, a held fault, an exact refresh timing and a full count of the restarted window.

The directed tasks get there in a fixed order:
1. Shrink the recovery code during init.
2. Raise the fault early in the normal window, before the missed-refresh limit.
3. Count falling edges from the first cycle of the recovery window.

This lets each refresh, and the expected reset-pulse edges, fall on a known window position.

// File: rtl/wdog_recov_pkg.sv
package wdog_recov_pkg;
  typedef enum logic [1:0] {
    PH_INIT  = 2'd0,
    PH_NORM  = 2'd1,
    PH_RECOV = 2'd2,
    PH_PULSE = 2'd3
  } wd_phase_e;

  localparam int CODE_W = 4;
endpackage

// File: rtl/wdog_rec_cfg.sv
module wdog_rec_cfg #(
  parameter int CODE_W   = 4,
  parameter int STEP_CYC = 16,
  parameter int CW       = 8,
  parameter int CODE_RST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic [CW-1:0]     rec_len
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst)        code_q <= CODE_W'(CODE_RST);
    else if (wr_en) code_q <= wr_code;
  end

  // length in cycles = (code + 1) steps
  always_comb rec_len = CW'((int'(code_q) + 1) * STEP_CYC);
endmodule

// File: rtl/wdog_win_timer.sv
module wdog_win_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clear) cnt_o <= '0;
    else              cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen #(
  parameter int WIDTH_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic pulse_o,
  output logic last_o
);
  localparam int PW = $clog2(WIDTH_CYC + 1);
  logic [PW-1:0] pcnt;

  assign last_o = pulse_o && (pcnt == PW'(WIDTH_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      pcnt    <= '0;
    end else if (start) begin
      pulse_o <= 1'b1;
      pcnt    <= '0;
    end else if (pulse_o) begin
      if (last_o) pulse_o <= 1'b0;
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_recov_pkg::*;
#(
  parameter int PERIOD_CYC = 64,
  parameter int CLOSED_CYC = 24,
  parameter int CW         = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_done_i,
  input  logic          refresh_i,
  input  logic          refresh_good_i,
  input  logic          fault_i,
  input  logic          recov_en_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] rec_len_i,
  input  logic          pulse_last_i,
  output wd_phase_e     phase_q,
  output logic          safe_q,
  output logic          err_q,
  output logic          tmr_clear,
  output logic          pulse_start
);
  localparam logic [CW-1:0] CLOSED_END = CW'(CLOSED_CYC);
  localparam logic [CW-1:0] PERIOD_END = CW'(PERIOD_CYC - 1);

  logic in_norm, in_rec, running;
  logic enter_rec, norm_act, norm_early, norm_bad, norm_miss;
  logic rec_good, rec_timeout;
  wd_phase_e phase_d;

  always_comb begin
    in_norm     = (phase_q == PH_NORM);
    in_rec      = (phase_q == PH_RECOV);
    running     = in_norm || in_rec;
    enter_rec   = in_norm && recov_en_i && fault_i && safe_q;
    norm_act    = in_norm && !enter_rec;
    norm_early  = norm_act && refresh_i && (cnt_i < CLOSED_END);
    norm_bad    = norm_act && refresh_i && !refresh_good_i;
    norm_miss   = norm_act && !refresh_i && (cnt_i == PERIOD_END);
    rec_good    = in_rec && refresh_i && refresh_good_i;
    rec_timeout = in_rec && !rec_good && (cnt_i == rec_len_i - 1'b1);
    pulse_start = rec_timeout;
    tmr_clear   = (phase_q == PH_INIT) || (phase_q == PH_PULSE) || enter_rec ||
                  (norm_act && refresh_i) || norm_miss || rec_good || rec_timeout;
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_INIT:  if (init_done_i) phase_d = PH_NORM;
      PH_NORM:  if (enter_rec) phase_d = PH_RECOV;
      PH_RECOV: begin
        if (rec_good && !fault_i) phase_d = PH_NORM;
        else if (rec_timeout)     phase_d = PH_PULSE;
      end
      PH_PULSE: if (pulse_last_i) phase_d = PH_INIT;
      default:  phase_d = PH_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_INIT;
      safe_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      err_q   <= norm_early || norm_bad || norm_miss;
      if (rec_timeout)                safe_q <= 1'b0;
      else if (rec_good && !fault_i)  safe_q <= 1'b0;
      else if (running && fault_i)    safe_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_recov.sv
module wdog_recov
  import wdog_recov_pkg::*;
#(
  parameter int PERIOD_CYC    = 64,
  parameter int CLOSED_CYC    = 24,
  parameter int REC_STEP_CYC  = 16,
  parameter int RST_PULSE_CYC = 8,
  parameter int REC_CODE_RST  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_done_i,
  input  logic              cfg_wr_i,
  input  logic [CODE_W-1:0] cfg_rec_code_i,
  input  logic              recov_en_i,
  input  logic              fault_i,
  input  logic              refresh_i,
  input  logic              refresh_good_i,
  output logic              safe_state_o,
  output logic              wd_err_o,
  output logic              rst_pulse_o,
  output logic              in_init_o,
  output logic              in_recov_o
);
  localparam int REC_MAX = (1 << CODE_W) * REC_STEP_CYC;
  localparam int SPAN    = (PERIOD_CYC > REC_MAX) ? PERIOD_CYC : REC_MAX;
  localparam int CW      = $clog2(SPAN + 1);

  wd_phase_e     phase;
  logic [CW-1:0] cnt, rec_len;
  logic          tmr_clear, pulse_start, pulse_last;

  wdog_rec_cfg #(
    .CODE_W(CODE_W), .STEP_CYC(REC_STEP_CYC), .CW(CW), .CODE_RST(REC_CODE_RST)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_i && (phase == PH_INIT)),
    .wr_code(cfg_rec_code_i),
    .rec_len(rec_len)
  );

  wdog_win_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .clear(tmr_clear), .cnt_o(cnt)
  );

  wdog_pulse_gen #(.WIDTH_CYC(RST_PULSE_CYC)) u_pulse (
    .clk(clk), .rst(rst), .start(pulse_start),
    .pulse_o(rst_pulse_o), .last_o(pulse_last)
  );

  wdog_ctrl #(
    .PERIOD_CYC(PERIOD_CYC), .CLOSED_CYC(CLOSED_CYC), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .init_done_i(init_done_i),
    .refresh_i(refresh_i),
    .refresh_good_i(refresh_good_i),
    .fault_i(fault_i),
    .recov_en_i(recov_en_i),
    .cnt_i(cnt),
    .rec_len_i(rec_len),
    .pulse_last_i(pulse_last),
    .phase_q(phase),
    .safe_q(safe_state_o),
    .err_q(wd_err_o),
    .tmr_clear(tmr_clear),
    .pulse_start(pulse_start)
  );

  assign in_init_o  = (phase == PH_INIT);
  assign in_recov_o = (phase == PH_RECOV);
endmodule

// File: rtl/wdog_recov_chk.sv
module wdog_recov_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          recov_en_i,
  input logic          fault_i,
  input logic          safe_state_o,
  input logic          wd_err_o,
  input logic          rst_pulse_o,
  input logic          in_init_o,
  input logic          in_recov_o,
  input logic [CW-1:0] rec_len
);
  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({in_init_o, in_recov_o, rst_pulse_o}));

  // R3
  len_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !in_init_o |=> $stable(rec_len));

  // R4
  err_norm_only_chk: assert property (@(posedge clk) disable iff (rst)
    wd_err_o |-> !in_recov_o && !in_init_o && !rst_pulse_o);

  // R8
  rec_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_recov_o) |-> $past(fault_i) && $past(safe_state_o) && $past(recov_en_i));

  // R10
  rec_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(in_recov_o) |-> rst_pulse_o || (!safe_state_o && !in_init_o));

  // R12
  pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_pulse_o) |-> $past(in_recov_o) && !safe_state_o);

  // R13
  no_rec_dis_chk: assert property (@(posedge clk) disable iff (rst)
    (!recov_en_i && !in_recov_o) |=> !in_recov_o);
endmodule

bind wdog_recov wdog_recov_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .recov_en_i(recov_en_i), .fault_i(fault_i),
  .safe_state_o(safe_state_o), .wd_err_o(wd_err_o), .rst_pulse_o(rst_pulse_o),
  .in_init_o(in_init_o), .in_recov_o(in_recov_o), .rec_len(rec_len)
);

// File: tb/wdog_recov_tb.sv
`timescale 1ns/1ps
module wdog_recov_tb;
  localparam int PER  = 20;
  localparam int CLO  = 8;
  localparam int STEP = 4;
  localparam int RW   = 5;
  localparam int CRST = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_done = 0, cfg_wr = 0, recov_en = 1, fault = 0, refresh = 0, good = 0;
  logic [3:0] code = '0;
  logic safe, err, pulse, in_init, in_rec;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  wdog_recov #(
    .PERIOD_CYC(PER), .CLOSED_CYC(CLO), .REC_STEP_CYC(STEP),
    .RST_PULSE_CYC(RW), .REC_CODE_RST(CRST)
  ) u_dut (
    .clk(clk), .rst(rst), .init_done_i(init_done), .cfg_wr_i(cfg_wr),
    .cfg_rec_code_i(code), .recov_en_i(recov_en), .fault_i(fault),
    .refresh_i(refresh), .refresh_good_i(good), .safe_state_o(safe),
    .wd_err_o(err), .rst_pulse_o(pulse), .in_init_o(in_init), .in_recov_o(in_rec)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; init_done = 0; cfg_wr = 0; recov_en = 1; fault = 0; refresh = 0; good = 0;
    wait_n(3);
    rst = 0;
  endtask

  task automatic start_run();
    init_done = 1;
    @(negedge clk);
    init_done = 0;
  endtask

  task automatic pulse_refresh(logic g);
    refresh = 1; good = g;
    @(negedge clk);
    refresh = 0; good = 0;
  endtask

  task automatic enter_recovery();
    fault = 1;
    @(negedge clk);
    check("R7 safe set", safe, 1);
    check("R8 not yet", in_rec, 0);
    @(negedge clk);
    check("R8 entry", in_rec, 1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 init", in_init, 1);
    check("R1 recov", in_rec, 0);
    check("R1 err", err, 0);
    check("R1 pulse", pulse, 0);
    check("R1 safe", safe, 0);
    start_run();
    check("R2 leave init", in_init, 0);
    enter_recovery();
    wait_n(3 * STEP - 1);
    check("R1 default len no pulse", pulse, 0);
    @(negedge clk);
    check("R1 default len pulse", pulse, 1);
  endtask

  task automatic t_normal_ok();
    do_reset();
    start_run();
    wait_n(CLO);
    pulse_refresh(1);
    check("R4 open ok", err, 0);
    wait_n(PER - 1);
    check("R4 restarted no err", err, 0);
    @(negedge clk);
    check("R5 miss after restart", err, 1);
  endtask

  task automatic t_closed();
    do_reset();
    start_run();
    wait_n(CLO - 1);
    pulse_refresh(1);
    check("R4 closed err", err, 1);
    @(negedge clk);
    check("R4 err one cycle", err, 0);
  endtask

  task automatic t_bad();
    do_reset();
    start_run();
    wait_n(CLO + 2);
    pulse_refresh(0);
    check("R6 bad refresh err", err, 1);
  endtask

  task automatic t_miss();
    do_reset();
    start_run();
    wait_n(PER - 1);
    check("R5 no err before end", err, 0);
    @(negedge clk);
    check("R5 miss err", err, 1);
  endtask

  task automatic t_timeout_cfg();
    do_reset();
    code = 4'd1; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
    start_run();
    code = 4'd5; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
    enter_recovery();
    wait_n(2 * STEP - 1);
    check("R3 R9 len no pulse", pulse, 0);
    check("R9 still recov", in_rec, 1);
    @(negedge clk);
    check("R12 pulse on", pulse, 1);
    check("R12 recov off", in_rec, 0);
    check("R12 safe clr", safe, 0);
    wait_n(RW - 1);
    check("R12 pulse width", pulse, 1);
    @(negedge clk);
    check("R12 pulse off", pulse, 0);
    check("R12 back init", in_init, 1);
    fault = 0;
  endtask

  task automatic t_return();
    do_reset();
    start_run();
    enter_recovery();
    wait_n(3);
    fault = 0;
    pulse_refresh(1);
    check("R10 recov off", in_rec, 0);
    check("R10 safe clr", safe, 0);
    check("R10 normal", in_init, 0);
    wait_n(PER - 1);
    check("R10 fresh window", err, 0);
    @(negedge clk);
    check("R10 miss", err, 1);
  endtask

  task automatic t_again();
    do_reset();
    start_run();
    enter_recovery();
    pulse_refresh(1);
    check("R9 pos0 accepted", in_rec, 1);
    check("R9 no err", err, 0);
    wait_n(5);
    pulse_refresh(1);
    check("R11 still recov", in_rec, 1);
    check("R11 safe held", safe, 1);
    wait_n(2);
    pulse_refresh(0);
    wait_n(3 * STEP - 4);
    check("R11 R9 full new window", pulse, 0);
    @(negedge clk);
    check("R11 timeout", pulse, 1);
    fault = 0;
  endtask

  task automatic t_disabled();
    do_reset();
    recov_en = 0;
    start_run();
    fault = 1;
    wait_n(6);
    check("R13 safe", safe, 1);
    check("R13 no recov", in_rec, 0);
    wait_n(PER - 7);
    check("R13 no err yet", err, 0);
    @(negedge clk);
    check("R13 miss err", err, 1);
    fault = 0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_normal_ok();
    t_closed();
    t_bad();
    t_miss();
    t_timeout_cfg();
    t_return();
    t_again();
    t_disabled();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule